// File: doc/BRIEF.md
# Unsigned Fixed-Point Reciprocal Estimate Vector Unit

This block takes a packed vector of 32-bit unsigned lanes and returns, for each lane, a coarse reciprocal estimate. Each operand is read as a fraction in [0, 1), with bit 31 worth one half. When that top bit is set, the operand lies in [0.5, 1) and its eight bits just below the top bit pick one of 256 estimate points. The result is a fixed-point value whose top bit is always on. It carries eight significant bits of the estimate and is zero below them. An operand below one half cannot be normalised this way. It returns the all-ones saturation value instead.

A width select enables either the lower two lanes or all four lanes. Lanes that are not enabled return zero. A request for 64-bit elements is not a legal form for this operation. Such a request is flagged on an error output and leaves the result register unchanged. Results are registered and appear one clock after the request strobe. The unit has no exception flags. Its integer computation cannot overflow or trap.

Top module: `recip_vec_unit`

## Requirements
- R1: A lane whose operand has bit 31 clear returns 0xFFFFFFFF.
- R2: A lane whose operand has bit 31 set returns bit 31 set and bits 30:23 equal to the low 8 bits of s. Here k is operand bits 30:23, q = 256 + k, r = floor(2^19 / (2q+1)) and s = (r+1)>>1. Equivalently, s is 131072/(q+0.5) rounded to the nearest integer.
- R3: On the estimate path, result bits 22:0 are zero, and operand bits 22:0 have no effect on the result.
- R4: With `in_wide`=1, lanes 0 to 3 are all computed. With `in_wide`=0, lanes 0 and 1 are computed and lanes 2 and 3 (`out_data` bits 127:64) return zero whatever their operands. Lane i sits at bits 32i+31:32i.
- R5: A request with `in_valid`=1 and `in_dbl`=0 makes `out_valid` high for exactly the next cycle, with `out_data` holding that request's results in the same cycle.
- R6: A request with `in_valid`=1 and `in_dbl`=1 makes `out_err` high for exactly the next cycle. In that cycle `out_valid` is low and `out_data` keeps its previous value.
- R7: After synchronous reset, `out_valid`, `out_err` and `out_data` are all zero.
- R8: The estimate endpoints: operand bits 30:23 = 0x00 gives 0xFF800000, and 0xFF gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_wide | input | 1 | 1: four lanes active, 0: two lanes active |
| in_dbl | input | 1 | Request asks for 64-bit elements (illegal) |
| in_data | input | 128 | Packed operands, lane i at bits 32i+31:32i |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| out_err | output | 1 | Illegal-element-size strobe |
| out_data | output | 128 | Packed registered results |

## Verification
The bench builds the unit with its defaults: four lanes of 32 bits and an 8-bit estimate index. With an 8-bit index there are only 256 distinct estimate points, so every point is swept in four-lane mode and again in two-lane mode. In two-lane mode the upper lanes carry random operands that must come back as zero. Pseudo-random low operand bits show that only the index bits matter. Separate runs cover below-half operands, the two ends of the estimate table, and a 64-bit request placed between legal ones to show that it leaves the results untouched.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

    localparam int DEF_LANE_W   = 32;
    localparam int DEF_EST_BITS = 8;
    localparam int DEF_LANES    = 4;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_OK   = 2'd1,
        REQ_BAD  = 2'd2
    } req_kind_e;

    typedef struct packed {
        logic wide;
        logic dbl;
        logic valid;
    } req_ctrl_t;

    // Rounded reciprocal of (2^est_bits + idx + 0.5) / 2^(est_bits+1),
    // scaled by 2^est_bits; the caller keeps the low est_bits bits.
    function automatic int unsigned seed_frac(input int unsigned idx,
                                              input int unsigned est_bits);
        int unsigned q;
        int unsigned r;
        int unsigned s;
        q = (32'd1 << est_bits) + idx;
        r = (32'd1 << (2 * est_bits + 3)) / (2 * q + 1);
        s = (r + 1) >> 1;
        return s;
    endfunction

    function automatic req_kind_e classify(input req_ctrl_t c);
        if (!c.valid)
            return REQ_IDLE;
        else if (c.dbl)
            return REQ_BAD;
        else
            return REQ_OK;
    endfunction

endpackage

// File: rtl/recip_seed_lane.sv
module recip_seed_lane
    import recip_est_pkg::*;
#(
    parameter int LANE_W   = DEF_LANE_W,
    parameter int EST_BITS = DEF_EST_BITS
) (
    input  logic [LANE_W-1:0] opnd,
    output logic [LANE_W-1:0] est
);
    localparam int HID = LANE_W - 1;
    localparam int PAD = LANE_W - 1 - EST_BITS;

    logic [EST_BITS-1:0] idx;
    int unsigned         s_full;

    always_comb begin
        idx    = opnd[HID-1 -: EST_BITS];
        s_full = seed_frac(32'(idx), EST_BITS);
        if (!opnd[HID])
            est = '1;
        else
            est = {1'b1, s_full[EST_BITS-1:0], {PAD{1'b0}}};
    end
endmodule

// File: rtl/recip_vec_out_reg.sv
module recip_vec_out_reg
    import recip_est_pkg::*;
#(
    parameter int NUM_LANES = DEF_LANES,
    parameter int LANE_W    = DEF_LANE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  req_kind_e                     kind,
    input  logic                          wide,
    input  logic [NUM_LANES*LANE_W-1:0]   est_in,
    output logic                          valid_q,
    output logic                          err_q,
    output logic [NUM_LANES*LANE_W-1:0]   data_q
);
    localparam int HALF = NUM_LANES / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= (kind == REQ_OK);
            err_q   <= (kind == REQ_BAD);
        end
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam bit ALWAYS_ON = (i < HALF);
        always_ff @(posedge clk) begin
            if (rst)
                data_q[i*LANE_W +: LANE_W] <= '0;
            else if (kind == REQ_OK)
                data_q[i*LANE_W +: LANE_W] <= (ALWAYS_ON || wide) ?
                                              est_in[i*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/recip_vec_unit.sv
module recip_vec_unit
    import recip_est_pkg::*;
#(
    parameter int NUM_LANES = DEF_LANES,
    parameter int LANE_W    = DEF_LANE_W,
    parameter int EST_BITS  = DEF_EST_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_wide,
    input  logic                          in_dbl,
    input  logic [NUM_LANES*LANE_W-1:0]   in_data,
    output logic                          out_valid,
    output logic                          out_err,
    output logic [NUM_LANES*LANE_W-1:0]   out_data
);
    req_ctrl_t                     ctrl;
    req_kind_e                     kind;
    logic [NUM_LANES*LANE_W-1:0]   est_all;

    always_comb begin
        ctrl.valid = in_valid;
        ctrl.wide  = in_wide;
        ctrl.dbl   = in_dbl;
        kind       = classify(ctrl);
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_seed
        recip_seed_lane #(
            .LANE_W   (LANE_W),
            .EST_BITS (EST_BITS)
        ) u_seed (
            .opnd (in_data[i*LANE_W +: LANE_W]),
            .est  (est_all[i*LANE_W +: LANE_W])
        );
    end

    recip_vec_out_reg #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .wide    (ctrl.wide),
        .est_in  (est_all),
        .valid_q (out_valid),
        .err_q   (out_err),
        .data_q  (out_data)
    );
endmodule

// File: rtl/recip_vec_chk.sv
module recip_vec_chk #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          in_wide,
    input logic                          in_dbl,
    input logic [NUM_LANES*LANE_W-1:0]   in_data,
    input logic                          out_valid,
    input logic                          out_err,
    input logic [NUM_LANES*LANE_W-1:0]   out_data
);
    localparam int HALF = NUM_LANES / 2;
    localparam int TOPW = (NUM_LANES - HALF) * LANE_W;

    assert_below_half_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dbl && !in_data[LANE_W-1]) |=> (out_data[LANE_W-1:0] == '1));

    for (genvar i = 0; i < HALF; i++) begin : g_top
        assert_top_bit_R2: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_data[i*LANE_W + LANE_W - 1]);
    end

    assert_narrow_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dbl && !in_wide) |=> (out_data[NUM_LANES*LANE_W-1 -: TOPW] == '0));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dbl) |=> out_valid);

    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_err));

    assert_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dbl) |=> (out_err && !out_valid && $stable(out_data)));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err));
endmodule

bind recip_vec_unit recip_vec_chk #(
    .NUM_LANES (NUM_LANES),
    .LANE_W    (LANE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .in_dbl    (in_dbl),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data)
);

// File: tb/test_recip_vec_unit.sv
`timescale 1ns/1ps
module test_recip_vec_unit;
    localparam int NL = 4;
    localparam int LW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid, in_wide, in_dbl;
    logic [NL*LW-1:0] in_data;
    logic            out_valid, out_err;
    logic [NL*LW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    recip_vec_unit #(.NUM_LANES(NL), .LANE_W(LW), .EST_BITS(8)) i_recip_vec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
        .in_dbl(in_dbl), .in_data(in_data), .out_valid(out_valid),
        .out_err(out_err), .out_data(out_data)
    );

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return v * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a);
        int  q;
        int  s;
        real x;
        logic [31:0] sv;
        if (!a[31]) return 32'hFFFF_FFFF;
        q  = 256 + int'(a[30:23]);
        x  = 131072.0 / (real'(q) + 0.5);
        s  = $rtoi($floor(x + 0.5));
        sv = 32'(s);
        return {1'b1, sv[7:0], 23'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic wide, input logic dbl, input logic [NL*LW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_wide = wide; in_dbl = dbl; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_dbl = 1'b0;
    endtask

    function automatic logic [31:0] lane(input logic [NL*LW-1:0] v, input int i);
        return v[i*LW +: LW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NL*LW-1:0] d;
        logic [NL*LW-1:0] held;
        rst = 1'b1; in_valid = 0; in_wide = 0; in_dbl = 0; in_data = '0;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 valid", {31'b0, out_valid}, 32'd0);
        chk("R7 err", {31'b0, out_err}, 32'd0);
        for (int i = 0; i < NL; i++) chk("R7 data", lane(out_data, i), 32'd0);
        rst = 1'b0;

        // R2/R3 full sweep, four lanes, random low bits
        for (int b = 0; b < 64; b++) begin
            for (int i = 0; i < NL; i++) begin
                seed = nxt(seed);
                d[i*LW +: LW] = {1'b1, 8'(b*4+i), seed[22:0]};
            end
            send(1'b1, 1'b0, d);
            chk("R5 valid", {31'b0, out_valid}, 32'd1);
            for (int i = 0; i < NL; i++)
                chk("R2 R3 R4 wide lane", lane(out_data, i), model(lane(d, i)));
        end

        // R4 two-lane mode, upper lanes random
        for (int b = 0; b < 128; b++) begin
            for (int i = 0; i < NL; i++) begin
                seed = nxt(seed);
                d[i*LW +: LW] = (i < NL/2) ? {1'b1, 8'(b*2+i), seed[22:0]} : seed;
            end
            send(1'b0, 1'b0, d);
            for (int i = 0; i < NL; i++)
                chk("R2 R4 narrow lane", lane(out_data, i),
                    (i < NL/2) ? model(lane(d, i)) : 32'd0);
        end

        // R1 below-half operands
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < NL; i++) begin
                seed = nxt(seed);
                d[i*LW +: LW] = {1'b0, seed[30:0]};
            end
            if (k == 0) d[LW-1:0] = 32'h0;
            if (k == 1) d[LW-1:0] = 32'h7FFF_FFFF;
            send(1'b1, 1'b0, d);
            for (int i = 0; i < NL; i++)
                chk("R1 below half", lane(out_data, i), 32'hFFFF_FFFF);
        end

        // R8 endpoints, R3 low bits ignored
        d = {32'hFFFF_FFFF, 32'h807F_FFFF, 32'hFF80_0000, 32'h8000_0000};
        send(1'b1, 1'b0, d);
        chk("R8 idx00", lane(out_data, 0), 32'hFF80_0000);
        chk("R8 idxFF", lane(out_data, 1), 32'h8000_0000);
        chk("R3 low ones", lane(out_data, 2), 32'hFF80_0000);
        chk("R3 low ones idxFF", lane(out_data, 3), 32'h8000_0000);

        // R5 pulse lasts one cycle
        @(negedge clk);
        chk("R5 pulse end", {31'b0, out_valid}, 32'd0);

        // R6 rejected 64-bit request
        held = out_data;
        seed = nxt(seed);
        send(1'b1, 1'b1, {4{seed}});
        chk("R6 err", {31'b0, out_err}, 32'd1);
        chk("R6 no valid", {31'b0, out_valid}, 32'd0);
        for (int i = 0; i < NL; i++) chk("R6 data held", lane(out_data, i), lane(held, i));
        @(negedge clk);
        chk("R6 err pulse end", {31'b0, out_err}, 32'd0);
        for (int i = 0; i < NL; i++) chk("R6 data still held", lane(out_data, i), lane(held, i));

        // back-to-back legal after reject
        d = {32'h0, 32'h8100_0000, 32'hC000_0000, 32'h1234_5678};
        send(1'b1, 1'b0, d);
        for (int i = 0; i < NL; i++) chk("R1 R2 after reject", lane(out_data, i), model(lane(d, i)));

        // R7 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < NL; i++) chk("R7 re-reset data", lane(out_data, i), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule